// File: doc/BRIEF.md
# Pixel Format Packer (4:4:4 / 4:2:2)

This block sits behind a three-channel video digitizer. On every pixel clock it takes one 8-bit sample from each of three channels and forms the output bus. In full mode (4:4:4, for RGB or any unsubsampled source) all three channels pass through unchanged on a 24-bit bus. In packed mode (4:2:2, for a luma/colour-difference source) channel 0 is taken as luma (Y), and channels 1 and 2 as the blue and red colour differences. Y goes out on the low 8-bit lane every clock. The blue and red differences take turns on a second 8-bit lane, so each of them runs at half the luma rate. A downstream device that has only a 16-bit port can then connect to the bus directly.

Chroma is subsampled by averaging each pair of neighbouring pixels, with rounding. The colour-difference values are delayed so that each one lines up with the Y samples it belongs to. A small state machine assigns a chroma slot to each pixel and keeps the format of a whole line fixed. The select input is taken only at a line start, and the slot order restarts on every line. The latency is fixed at two clocks in both modes.

The slot machine has three states. FULL is 4:4:4 mode. WANT_CB means 4:2:2 mode, with the next pixel taking a Cb slot. WANT_CR means 4:2:2 mode, with the next pixel taking a Cr slot. A valid line-start pixel forces the slot choice and moves the machine to FULL (select low) or to WANT_CR (select high, the start pixel itself taking Cb). A valid pixel that is not a line start makes one of these moves: FULL stays FULL, WANT_CB goes to WANT_CR, and WANT_CR goes to WANT_CB. Idle cycles hold the state.

Top module: `pix_fmt_pack`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, out_valid, out_data and out_phase are all 0, whatever the inputs.
- R2: A pixel sampled with in_valid=1 on rising edge k appears on the outputs just after edge k+2 in both modes, and out_valid follows in_valid with that same delay.
- R3: In 4:4:4 mode out_data is {in_ch2, in_ch1, in_ch0} (channel 0 in bits 7:0), and out_phase is 0.
- R4: In 4:2:2 mode bits 7:0 carry channel 0 (Y) of the same pixel, bits 15:8 carry the chroma lane and bits 23:16 are 0.
- R5: In 4:2:2 mode the line-start pixel takes a Cb slot (out_phase=0, chroma taken from channel 1). The next valid pixel takes a Cr slot (out_phase=1, chroma taken from channel 2), and the slots keep alternating on each valid pixel to the end of the line.
- R6: A Cb-slot pixel forms a pair when the very next cycle holds a valid pixel that is not a line start. The Cb lane of the first pixel is then (ch1_first + ch1_second + 1) >> 1, and the Cr lane of the second pixel is (ch2_first + ch2_second + 1) >> 1.
- R7: A Cb-slot pixel whose next cycle is idle or a line start carries its own channel 1 value. The following Cr-slot pixel then carries its own channel 2 value.
- R8: mode_sel (1 = 4:2:2, 0 = 4:4:4) is taken only from a valid line-start pixel and is ignored at all other times. From reset until the first line start the block is in 4:4:4 mode.
- R9: Whenever out_valid is 0, out_data and out_phase are 0.
- R10: A line start always begins with a Cb slot in 4:2:2 mode, wherever the previous line stopped. A Cb-slot pixel just before a line start is left unpaired, as R7 describes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Format request, 1 = 4:2:2, 0 = 4:4:4, taken at a line start |
| in_valid | input | 1 | Active-video pixel present this cycle |
| in_sol | input | 1 | Marks the first active pixel of a line |
| in_ch0 | input | 8 | Channel 0 sample (R or Y) |
| in_ch1 | input | 8 | Channel 1 sample (G or Cb) |
| in_ch2 | input | 8 | Channel 2 sample (B or Cr) |
| out_valid | output | 1 | Output pixel present |
| out_data | output | 24 | Formatted pixel bus |
| out_phase | output | 1 | Chroma lane content, 0 = Cb, 1 = Cr |

## Verification
Pair completion and line restart can fall in the same cycle. This happens when a Cb-slot pixel is waiting for its partner and the very next pixel is a line start, which may also switch the format. The bench provokes this by driving a new line, in each mode, straight after a line that ended on a Cb slot. It judges the result by checking that the old pixel keeps its own Cb value, and that the new pixel comes out as a fresh Cb slot (phase 0) or as a full RGB word. A mid-line change of mode_sel, paired with a later line start, is checked in the same way for the format latch.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    localparam int NUM_CH = 3;

    // Per-pixel slot assignment carried down the pipeline
    typedef enum logic [1:0] {
        SLOT_RGB = 2'd0,
        SLOT_CB  = 2'd1,
        SLOT_CR  = 2'd2
    } slot_e;

    // Slot machine state: format plus which chroma slot comes next
    typedef enum logic [1:0] {
        ST_FULL    = 2'd0,
        ST_WANT_CB = 2'd1,
        ST_WANT_CR = 2'd2
    } fmt_state_e;

endpackage

// File: rtl/fmt_slot_fsm.sv
module fmt_slot_fsm
    import fmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  logic  in_sol,
    input  logic  mode_sel,
    output slot_e slot
);

    fmt_state_e state_q;
    fmt_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FULL;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: line start latches the format, other pixels alternate
    always_comb begin
        state_d = state_q;
        if (in_valid) begin
            if (in_sol) begin
                state_d = mode_sel ? ST_WANT_CR : ST_FULL;
            end else begin
                unique case (state_q)
                    ST_FULL:    state_d = ST_FULL;
                    ST_WANT_CB: state_d = ST_WANT_CR;
                    ST_WANT_CR: state_d = ST_WANT_CB;
                    default:    state_d = ST_FULL;
                endcase
            end
        end
    end

    // Output: slot for the pixel on the inputs this cycle
    always_comb begin
        slot = SLOT_RGB;
        if (in_valid && in_sol) begin
            slot = mode_sel ? SLOT_CB : SLOT_RGB;
        end else begin
            unique case (state_q)
                ST_FULL:    slot = SLOT_RGB;
                ST_WANT_CB: slot = SLOT_CB;
                ST_WANT_CR: slot = SLOT_CR;
                default:    slot = SLOT_RGB;
            endcase
        end
    end

    // R5: a Cb slot is followed by a Cr slot unless a gap or line start intervenes
    p_cb_then_cr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && slot == SLOT_CB) |=> (!in_valid || in_sol || slot == SLOT_CR));

    // R8: a 4:4:4 line stays 4:4:4 until the next line start
    p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && slot == SLOT_RGB) |=> (in_sol || slot == SLOT_RGB));

endmodule

// File: rtl/fmt_pipe.sv
module fmt_pipe #(
    parameter int DATA_W = 24,
    parameter int STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [1:0]                     in_slot,
    input  logic [DATA_W-1:0]              in_data,
    output logic [STAGES-1:0]              tap_valid,
    output logic [STAGES-1:0][1:0]         tap_slot,
    output logic [STAGES-1:0][DATA_W-1:0]  tap_data
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic              v_src;
        logic [1:0]        s_src;
        logic [DATA_W-1:0] d_src;
        logic              v_q;
        logic [1:0]        s_q;
        logic [DATA_W-1:0] d_q;

        if (g == 0) begin : g_head
            assign v_src = in_valid;
            assign s_src = in_slot;
            assign d_src = in_data;
        end else begin : g_tail
            assign v_src = tap_valid[g-1];
            assign s_src = tap_slot[g-1];
            assign d_src = tap_data[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                s_q <= 2'd0;
                d_q <= '0;
            end else begin
                v_q <= v_src;
                s_q <= s_src;
                d_q <= d_src;
            end
        end

        assign tap_valid[g] = v_q;
        assign tap_slot[g]  = s_q;
        assign tap_data[g]  = d_q;
    end

endmodule

// File: rtl/fmt_avg.sv
module fmt_avg #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    localparam int SUM_W = W + 1;

    logic [SUM_W-1:0] sum;

    // Round half up: add one before dropping the low bit
    assign sum = {1'b0, a} + {1'b0, b} + SUM_W'(1);
    assign y   = sum[SUM_W-1:1];

endmodule

// File: rtl/fmt_out_stage.sv
module fmt_out_stage
    import fmt_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cur_valid,
    input  logic [1:0]            cur_slot,
    input  logic [3*LANE_W-1:0]   cur_data,
    input  logic                  nxt_valid,
    input  logic [1:0]            nxt_slot,
    input  logic [2*LANE_W-1:0]   nxt_chroma,
    output logic                  out_valid,
    output logic [3*LANE_W-1:0]   out_data,
    output logic                  out_phase
);

    localparam int BUS_W    = 3 * LANE_W;
    localparam int CH_LANES = 2;

    logic [CH_LANES-1:0][LANE_W-1:0] pair_avg;

    for (genvar k = 0; k < CH_LANES; k++) begin : g_avg
        fmt_avg #(.W(LANE_W)) u_avg (
            .a (cur_data[(k+1)*LANE_W +: LANE_W]),
            .b (nxt_chroma[k*LANE_W +: LANE_W]),
            .y (pair_avg[k])
        );
    end

    logic              paired;
    logic [LANE_W-1:0] cr_hold_q, cr_hold_d;
    logic              hold_ok_q, hold_ok_d;
    logic              v_d;
    logic [BUS_W-1:0]  d_d;
    logic              ph_d;
    logic [LANE_W-1:0] luma;

    assign paired = nxt_valid && (slot_e'(nxt_slot) == SLOT_CR);
    assign luma   = cur_data[LANE_W-1:0];

    // Output word for the pixel leaving the pipeline
    always_comb begin
        v_d       = cur_valid;
        d_d       = '0;
        ph_d      = 1'b0;
        cr_hold_d = cr_hold_q;
        hold_ok_d = hold_ok_q;
        if (cur_valid) begin
            unique case (slot_e'(cur_slot))
                SLOT_RGB: begin
                    d_d = cur_data;
                end
                SLOT_CB: begin
                    d_d = {{LANE_W{1'b0}},
                           (paired ? pair_avg[0] : cur_data[LANE_W +: LANE_W]),
                           luma};
                    cr_hold_d = pair_avg[1];
                    hold_ok_d = paired;
                end
                SLOT_CR: begin
                    d_d = {{LANE_W{1'b0}},
                           (hold_ok_q ? cr_hold_q : cur_data[2*LANE_W +: LANE_W]),
                           luma};
                    ph_d      = 1'b1;
                    hold_ok_d = 1'b0;
                end
                default: begin
                    d_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_phase <= 1'b0;
            cr_hold_q <= '0;
            hold_ok_q <= 1'b0;
        end else begin
            out_valid <= v_d;
            out_data  <= d_d;
            out_phase <= ph_d;
            cr_hold_q <= cr_hold_d;
            hold_ok_q <= hold_ok_d;
        end
    end

    // R9: an idle output slot carries no data and phase 0
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0 && !out_phase));

    // R4: packed pixels leave the top lane clear
    p_upper_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && slot_e'(cur_slot) != SLOT_RGB) |=> (out_data[BUS_W-1:2*LANE_W] == '0));

    // R6: a paired Cb pixel is followed straight away by its Cr partner
    p_pair_then_cr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && slot_e'(cur_slot) == SLOT_CB && paired) |=> ##1 (out_valid && out_phase));

endmodule

// File: rtl/pix_fmt_pack.sv
module pix_fmt_pack
    import fmt_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_sel,
    input  logic                       in_valid,
    input  logic                       in_sol,
    input  logic [LANE_W-1:0]          in_ch0,
    input  logic [LANE_W-1:0]          in_ch1,
    input  logic [LANE_W-1:0]          in_ch2,
    output logic                       out_valid,
    output logic [NUM_CH*LANE_W-1:0]   out_data,
    output logic                       out_phase
);

    localparam int BUS_W       = NUM_CH * LANE_W;
    localparam int PIPE_STAGES = 2;
    localparam int CUR         = PIPE_STAGES - 1;
    localparam int NXT         = PIPE_STAGES - 2;

    slot_e                                in_slot;
    logic [PIPE_STAGES-1:0]               tap_valid;
    logic [PIPE_STAGES-1:0][1:0]          tap_slot;
    logic [PIPE_STAGES-1:0][BUS_W-1:0]    tap_data;
    logic                                 unused_nxt_luma;

    fmt_slot_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .mode_sel (mode_sel),
        .slot     (in_slot)
    );

    fmt_pipe #(.DATA_W(BUS_W), .STAGES(PIPE_STAGES)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_slot   (in_slot),
        .in_data   ({in_ch2, in_ch1, in_ch0}),
        .tap_valid (tap_valid),
        .tap_slot  (tap_slot),
        .tap_data  (tap_data)
    );

    fmt_out_stage #(.LANE_W(LANE_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_valid  (tap_valid[CUR]),
        .cur_slot   (tap_slot[CUR]),
        .cur_data   (tap_data[CUR]),
        .nxt_valid  (tap_valid[NXT]),
        .nxt_slot   (tap_slot[NXT]),
        .nxt_chroma (tap_data[NXT][BUS_W-1:LANE_W]),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_phase  (out_phase)
    );

    assign unused_nxt_luma = ^tap_data[NXT][LANE_W-1:0];

    // Cycles since reset, used to keep the latency check inside history
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R2: output valid trails input valid by the fixed pipeline depth
    p_fixed_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R5: a packed line opens on a Cb slot
    p_line_first_cb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol && mode_sel) |=> ##2 (out_valid && !out_phase));

    // R3: a full-format line start passes channel 0 on the low lane
    p_rgb_luma_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol && !mode_sel) |=> ##2
            (out_valid && !out_phase && out_data[LANE_W-1:0] == $past(in_ch0, 3)));

endmodule

// File: tb/pix_fmt_pack_bench.sv
`timescale 1ns/1ps
module pix_fmt_pack_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_sel, in_valid, in_sol;
    logic [7:0]  in_ch0, in_ch1, in_ch2;
    logic        out_valid, out_phase;
    logic [23:0] out_data;

    pix_fmt_pack u_pix_fmt_pack (
        .clk (clk), .rst_n (rst_n), .mode_sel (mode_sel),
        .in_valid (in_valid), .in_sol (in_sol),
        .in_ch0 (in_ch0), .in_ch1 (in_ch1), .in_ch2 (in_ch2),
        .out_valid (out_valid), .out_data (out_data), .out_phase (out_phase)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic        v;
        logic        ph;
        logic [23:0] d;
        string       tag;
    } exp_t;

    exp_t  q[$];
    exp_t  mon_e;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model state
    bit         m_mode = 0, m_crnext = 0, m_hold_ok = 0, have_prev = 0;
    logic [7:0] m_hold = 8'h0;
    bit         p_v;
    int         p_slot;
    logic [7:0] p0, p1, p2;
    string      p_tag;

    function automatic logic [7:0] avg8(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b} + 9'd1;
        return s[8:1];
    endfunction

    task automatic note(input bit ok, input string tag, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Driver: applies one cycle and pushes the expectation of the previous one
    task automatic drive(input bit v, input bit s, input bit m,
                         input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        int   c_slot;
        exp_t e;
        bit   paired;
        @(negedge clk);
        in_valid = v; in_sol = s; mode_sel = m;
        in_ch0 = a; in_ch1 = b; in_ch2 = c;
        c_slot = 0;
        if (v && s) begin
            m_mode = m; c_slot = m ? 1 : 0; m_crnext = m;
        end else if (v) begin
            if (!m_mode) c_slot = 0;
            else if (m_crnext) begin c_slot = 2; m_crnext = 0; end
            else begin c_slot = 1; m_crnext = 1; end
        end
        if (have_prev) begin
            e.v = p_v; e.ph = 1'b0; e.d = 24'h0; e.tag = p_tag;
            if (p_v) begin
                case (p_slot)
                    0: e.d = {p2, p1, p0};
                    1: begin
                        paired    = v && (c_slot == 2);
                        e.d       = {8'h00, (paired ? avg8(p1, b) : p1), p0};
                        m_hold    = avg8(p2, c);
                        m_hold_ok = paired;
                    end
                    default: begin
                        e.d  = {8'h00, (m_hold_ok ? m_hold : p2), p0};
                        e.ph = 1'b1;
                        m_hold_ok = 0;
                    end
                endcase
            end
            q.push_back(e);
        end
        have_prev = 1; p_v = v; p_slot = c_slot;
        p0 = a; p1 = b; p2 = c; p_tag = cur_req;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 8'h00, 8'h00, 8'h00);
    endtask

    // Monitor: compares each output cycle against the queued expectation
    always @(posedge clk) begin
        #1;
        if (!done && q.size() >= 2) begin
            mon_e = q.pop_front();
            note({out_valid, out_phase, out_data} === {mon_e.v, mon_e.ph, mon_e.d},
                 mon_e.tag, "valid/phase/data",
                 {6'b0, out_valid, out_phase, out_data},
                 {6'b0, mon_e.v, mon_e.ph, mon_e.d});
        end
    end

    initial begin
        #(4 * 5000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: busy inputs while held in reset
        rst_n = 0; in_valid = 1; in_sol = 1; mode_sel = 1;
        in_ch0 = 8'hAA; in_ch1 = 8'hBB; in_ch2 = 8'hCC;
        repeat (3) @(negedge clk);
        note(out_valid === 1'b0, "R1", "out_valid in reset", {31'b0, out_valid}, 32'h0);
        note(out_data === 24'h0, "R1", "out_data in reset", {8'b0, out_data}, 32'h0);
        note(out_phase === 1'b0, "R1", "out_phase in reset", {31'b0, out_phase}, 32'h0);
        in_valid = 0; in_sol = 0; mode_sel = 0;
        in_ch0 = 0; in_ch1 = 0; in_ch2 = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        note({out_valid, out_phase, out_data} === 26'h0, "R1", "outputs after release",
             {6'b0, out_valid, out_phase, out_data}, 32'h0);

        // R8: before any line start the block is 4:4:4 even with mode_sel high
        cur_req = "R8";
        drive(1, 0, 1, 8'h11, 8'h22, 8'h33);
        drive(1, 0, 1, 8'h44, 8'h55, 8'h66);

        // R2 R3: full-format line
        cur_req = "R2 R3";
        drive(1, 1, 0, 8'h01, 8'h02, 8'h03);
        drive(1, 0, 0, 8'h10, 8'h20, 8'h30);
        drive(1, 0, 1, 8'hFE, 8'h7F, 8'h80);
        drive(1, 0, 0, 8'h5A, 8'hA5, 8'hC3);

        cur_req = "R9";
        idle(2);

        // R4 R5 R6: packed line with rounding on odd sums
        cur_req = "R4 R5 R6";
        drive(1, 1, 1, 8'h20, 8'h10, 8'hF0);
        drive(1, 0, 1, 8'h21, 8'h13, 8'hFF);
        drive(1, 0, 1, 8'h40, 8'hFF, 8'h00);
        drive(1, 0, 1, 8'h41, 8'hFF, 8'h01);
        drive(1, 0, 1, 8'h60, 8'h00, 8'h80);
        drive(1, 0, 1, 8'h61, 8'h01, 8'h81);

        // R8: mode_sel low mid-line has no effect
        cur_req = "R8";
        drive(1, 0, 0, 8'h70, 8'h33, 8'h44);
        drive(1, 0, 0, 8'h71, 8'h36, 8'h49);

        // R7: gap splits a pair
        cur_req = "R7";
        drive(1, 0, 1, 8'h80, 8'h50, 8'h60);
        idle(1);
        drive(1, 0, 1, 8'h81, 8'h90, 8'hA0);
        drive(1, 0, 1, 8'h82, 8'hB0, 8'hC0);
        idle(2);

        // R10: line starts arriving right after a Cb-slot pixel
        cur_req = "R10";
        drive(1, 1, 1, 8'h90, 8'h08, 8'h09);
        drive(1, 0, 1, 8'h91, 8'h0A, 8'h0B);
        drive(1, 0, 1, 8'h92, 8'h0C, 8'h0D);
        drive(1, 1, 1, 8'h93, 8'h0E, 8'h0F);
        drive(1, 0, 1, 8'h94, 8'h1E, 8'h1F);
        drive(1, 0, 1, 8'h95, 8'h2E, 8'h2F);
        drive(1, 1, 0, 8'h96, 8'h3E, 8'h3F);
        drive(1, 0, 1, 8'h97, 8'h4E, 8'h4F);

        cur_req = "R9";
        idle(4);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule